// File: doc/BRIEF.md
# DMA Channel Control and Status Registers

This block is the register front end of a single DMA channel. Software reaches four 32-bit words over a simple register bus: a control and status word, a running memory address, and two general-purpose words. From the control word the block drives three side-band signals towards the attached peripheral: a gated interrupt line, a one-cycle reset pulse and a level that lets the peripheral move data. The peripheral reports its own interrupt on an input pin. After each burst it reports the byte count, and the block adds that count to the address word. The movement of data is handled elsewhere.

The control word carries a fixed version code in its top nibble and several fields that software cannot write. A write of all zeros is turned into a drain request. Any write to the address word raises a sticky flag that shows a fresh address has been loaded.

Top module: `dma_chan_regs`

## Requirements
- R1: Bus address bits [3:2] select the word: 0 control, 1 address, 2 and 3 general-purpose. A read returns the selected word combinationally in the same cycle, and a write takes effect at the next rising clock edge.
- R2: Only accesses with all four byte enables set (`bus_be` = 4'hF) are accepted. A write with any other byte-enable value changes nothing, and a read with any other value returns zero.
- R3: Control bits 31:25 and 2:0 cannot be written and keep their value across a control write. Bits 31:28 always read as the version code 4'hA.
- R4: After reset the control word reads 0xA000_0000, the other three words read zero, and `irq_out`, `periph_rst` and `dma_en` are low.
- R5: A rising edge on `periph_irq` sets the pending bit (bit 0), and a falling edge clears it. `irq_out` is high exactly when both pending and interrupt-enable (bit 4) are set, one cycle after the event that caused the change.
- R6: A control write with bit 4 set raises `irq_out` on the next cycle if pending is already set. A control write with bit 4 clear lowers `irq_out` and leaves pending unchanged.
- R7: A control write with bit 7 set drives `periph_rst` high for exactly the one cycle after the write edge.
- R8: When bit 7 of a control write is clear, a written bit 6 (drain) is stored as 0. A write of all zeros stores bit 6 as 1, so the word reads 0xA000_0040 when no protected bits are set.
- R9: `dma_en` follows control bit 9. It rises after a write that sets bit 9 while it was clear, and falls after a write that clears it.
- R10: Any accepted write to the address word sets control bit 26 (loaded). The bit then stays set until reset, whatever is written to the control word.
- R11: A cycle with `xfer_valid` high adds `xfer_len` to the address word, modulo 2^32. A bus write to the address word in the same cycle takes priority, and the increment is dropped.
- R12: When a `periph_irq` edge and a control write fall in the same cycle, the pending bit takes its value from the edge and every other writable field takes its value from the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_be | input | 4 | Byte enables; must be 4'hF |
| bus_addr | input | ADDR_W | Byte address; bits [3:2] pick the word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| periph_irq | input | 1 | Interrupt level from the peripheral |
| xfer_valid | input | 1 | Peripheral finished a transfer this cycle |
| xfer_len | input | LEN_W | Bytes moved by that transfer |
| irq_out | output | 1 | Gated channel interrupt |
| periph_rst | output | 1 | One-cycle peripheral reset pulse |
| dma_en | output | 1 | DMA enable level to the peripheral |

## Verification
Two events can land on the same clock edge. The first is an edge on the peripheral interrupt during a control-word write. The second is a bus write to the address word during a transfer-count increment. The bench drives each pair in the same low clock phase. For the interrupt case it checks that the pending bit follows the edge while the enable follows the written data, and that `irq_out` reflects both combined. For the address case it checks that the written value lands and the increment is lost.

// File: rtl/dma_regs_pkg.sv
package dma_regs_pkg;
   localparam int unsigned WORD_W   = 32;
   localparam int unsigned NUM_REGS = 4;
   localparam int unsigned IDX_W    = $clog2(NUM_REGS);

   typedef enum logic [IDX_W-1:0] {
      IDX_CTRL = 2'd0,
      IDX_ADDR = 2'd1,
      IDX_GP0  = 2'd2,
      IDX_GP1  = 2'd3
   } reg_idx_e;

   // control field positions (software visible encoding)
   localparam int unsigned B_PEND   = 0;
   localparam int unsigned B_IEN    = 4;
   localparam int unsigned B_DRAIN  = 6;
   localparam int unsigned B_RST    = 7;
   localparam int unsigned B_TOMEM  = 8;
   localparam int unsigned B_DEN    = 9;
   localparam int unsigned B_LOADED = 26;

   localparam logic [WORD_W-1:0] PROT_MASK = 32'hFE00_0007;

   function automatic logic [WORD_W-1:0] ctrl_init(input logic [3:0] ver);
      return {ver, 28'h0};
   endfunction
endpackage

// File: rtl/dma_bus_decode.sv
module dma_bus_decode
   import dma_regs_pkg::*;
#(
   parameter int unsigned ADDR_W = 8
) (
   input  logic                bus_sel,
   input  logic                bus_wr,
   input  logic [3:0]          bus_be,
   input  logic [ADDR_W-1:0]   bus_addr,
   output logic [NUM_REGS-1:0] wr_stb,
   output logic [IDX_W-1:0]    rd_idx,
   output logic                rd_ok
);
   localparam int unsigned IDX_LSB = 2;

   logic full_word;
   assign full_word = (bus_be == 4'hF);
   assign rd_idx    = bus_addr[IDX_LSB +: IDX_W];
   assign rd_ok     = bus_sel & ~bus_wr & full_word;

   for (genvar g = 0; g < NUM_REGS; g++) begin : g_stb
      assign wr_stb[g] = bus_sel & bus_wr & full_word & (rd_idx == IDX_W'(g));
   end

   logic unused_lo;
   assign unused_lo = ^bus_addr[IDX_LSB-1:0];
   if (ADDR_W > IDX_LSB + IDX_W) begin : g_hi
      logic unused_hi;
      assign unused_hi = ^bus_addr[ADDR_W-1:IDX_LSB+IDX_W];
   end
endmodule

// File: rtl/dma_ctrl_reg.sv
module dma_ctrl_reg
   import dma_regs_pkg::*;
#(
   parameter logic [3:0] VERSION = 4'hA
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [WORD_W-1:0] wdata,
   input  logic              set_loaded,
   input  logic              irq_in,
   output logic [WORD_W-1:0] ctrl_q,
   output logic              irq_out,
   output logic              rst_pulse,
   output logic              dma_en
);
   logic              irq_in_q;
   logic              irq_q;
   logic              pulse_q;
   logic              rise, fall, pend_n;
   logic [WORD_W-1:0] wv;
   logic [WORD_W-1:0] ctrl_n;

   always_comb begin
      rise   = irq_in & ~irq_in_q;
      fall   = ~irq_in & irq_in_q;
      pend_n = rise ? 1'b1 : (fall ? 1'b0 : ctrl_q[B_PEND]);

      wv = wdata;
      if (!wdata[B_RST]) begin
         if (wdata[B_DRAIN])      wv[B_DRAIN] = 1'b0;
         else if (wdata == '0)    wv[B_DRAIN] = 1'b1;
      end

      ctrl_n = ctrl_q;
      if (wr) ctrl_n = (ctrl_q & PROT_MASK) | (wv & ~PROT_MASK);
      ctrl_n[31:28] = VERSION;
      if (set_loaded) ctrl_n[B_LOADED] = 1'b1;
      ctrl_n[B_PEND] = pend_n;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q   <= ctrl_init(VERSION);
         irq_in_q <= 1'b0;
         irq_q    <= 1'b0;
         pulse_q  <= 1'b0;
      end else begin
         ctrl_q   <= ctrl_n;
         irq_in_q <= irq_in;
         irq_q    <= ctrl_n[B_PEND] & ctrl_n[B_IEN];
         pulse_q  <= wr & wdata[B_RST];
      end
   end

   assign irq_out   = irq_q;
   assign rst_pulse = pulse_q;
   assign dma_en    = ctrl_q[B_DEN];

   AST_PROT_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && !set_loaded) |=> ctrl_q[27:25] == $past(ctrl_q[27:25])); // R3
   AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      irq_out |-> (ctrl_q[B_IEN] && ctrl_q[B_PEND])); // R5
   AST_IRQ_FALL_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_in_q && !irq_in) |=> (!irq_out && !ctrl_q[B_PEND])); // R5
   AST_ZERO_DRAINS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && wdata == '0) |=> ctrl_q[B_DRAIN]); // R8
   AST_EN_RISE_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dma_en) |-> $past(wr)); // R9
   AST_LOADED_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
      $past(ctrl_q[B_LOADED]) |-> ctrl_q[B_LOADED]); // R10
endmodule

// File: rtl/dma_addr_reg.sv
module dma_addr_reg
   import dma_regs_pkg::*;
#(
   parameter int unsigned LEN_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [WORD_W-1:0] wdata,
   input  logic              xfer_valid,
   input  logic [LEN_W-1:0]  xfer_len,
   output logic [WORD_W-1:0] addr_q
);
   logic [WORD_W-1:0] step;
   assign step = WORD_W'(xfer_len);

   always_ff @(posedge clk) begin
      if (!rst_n)          addr_q <= '0;
      else if (wr)         addr_q <= wdata;
      else if (xfer_valid) addr_q <= addr_q + step;
   end

   AST_ADDR_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_valid && !wr) |=> addr_q == $past(addr_q) + WORD_W'($past(xfer_len))); // R11
   AST_ADDR_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      wr |=> addr_q == $past(wdata)); // R11
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
   import dma_regs_pkg::*;
#(
   parameter int unsigned ADDR_W  = 8,
   parameter int unsigned LEN_W   = 16,
   parameter logic [3:0]  VERSION = 4'hA
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [3:0]        bus_be,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   input  logic              periph_irq,
   input  logic              xfer_valid,
   input  logic [LEN_W-1:0]  xfer_len,
   output logic              irq_out,
   output logic              periph_rst,
   output logic              dma_en
);
   localparam int unsigned NUM_GP = NUM_REGS - 2;

   if (ADDR_W < 4) begin : g_bad_addr
      $error("ADDR_W must cover address bits [3:2]");
   end
   if (LEN_W < 1 || LEN_W > WORD_W) begin : g_bad_len
      $error("LEN_W must lie between 1 and the word width");
   end

   logic [NUM_REGS-1:0] wr_stb;
   logic [IDX_W-1:0]    rd_idx;
   logic                rd_ok;
   logic [WORD_W-1:0]   ctrl_q;
   logic [WORD_W-1:0]   addr_q;
   logic [WORD_W-1:0]   gp_q [NUM_GP];

   dma_bus_decode #(.ADDR_W(ADDR_W)) u_dec (
      .bus_sel  (bus_sel),
      .bus_wr   (bus_wr),
      .bus_be   (bus_be),
      .bus_addr (bus_addr),
      .wr_stb   (wr_stb),
      .rd_idx   (rd_idx),
      .rd_ok    (rd_ok)
   );

   dma_ctrl_reg #(.VERSION(VERSION)) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr         (wr_stb[IDX_CTRL]),
      .wdata      (bus_wdata),
      .set_loaded (wr_stb[IDX_ADDR]),
      .irq_in     (periph_irq),
      .ctrl_q     (ctrl_q),
      .irq_out    (irq_out),
      .rst_pulse  (periph_rst),
      .dma_en     (dma_en)
   );

   dma_addr_reg #(.LEN_W(LEN_W)) u_addr (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr         (wr_stb[IDX_ADDR]),
      .wdata      (bus_wdata),
      .xfer_valid (xfer_valid),
      .xfer_len   (xfer_len),
      .addr_q     (addr_q)
   );

   for (genvar g = 0; g < NUM_GP; g++) begin : g_gp
      always_ff @(posedge clk) begin
         if (!rst_n)             gp_q[g] <= '0;
         else if (wr_stb[g + 2]) gp_q[g] <= bus_wdata;
      end
   end

   always_comb begin
      bus_rdata = '0;
      if (rd_ok) begin
         case (rd_idx)
            IDX_CTRL: bus_rdata = ctrl_q;
            IDX_ADDR: bus_rdata = addr_q;
            IDX_GP0:  bus_rdata = gp_q[0];
            default:  bus_rdata = gp_q[1];
         endcase
      end
   end

   AST_RST_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      periph_rst |-> $past(bus_sel && bus_wr && bus_be == 4'hF &&
                           bus_addr[3:2] == 2'd0 && bus_wdata[B_RST])); // R7
   AST_PARTIAL_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && bus_wr && bus_be != 4'hF) |=> $stable(gp_q[0]) && $stable(gp_q[1])); // R2
endmodule

// File: tb/dma_chan_regs_test.sv
module dma_chan_regs_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0, bus_wr = 1'b0;
   logic [3:0]  bus_be = 4'h0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        periph_irq = 1'b0;
   logic        xfer_valid = 1'b0;
   logic [15:0] xfer_len = '0;
   logic        irq_out, periph_rst, dma_en;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   dma_chan_regs #(.ADDR_W(8), .LEN_W(16)) uut (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_be(bus_be), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .periph_irq(periph_irq), .xfer_valid(xfer_valid),
      .xfer_len(xfer_len), .irq_out(irq_out), .periph_rst(periph_rst),
      .dma_en(dma_en)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr_word(input logic [1:0] idx, input logic [31:0] d,
                          input logic [3:0] be = 4'hF);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_be = be;
      bus_addr = {4'h0, idx, 2'b00}; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic rd_word(input logic [1:0] idx, output logic [31:0] d,
                          input logic [3:0] be = 4'hF);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_be = be;
      bus_addr = {4'h0, idx, 2'b00};
      #1 d = bus_rdata;
      bus_sel = 1'b0;
   endtask

   task automatic t_reset();
      logic [31:0] d;
      rd_word(2'd0, d); check("R4 ctrl", d, 32'hA000_0000);
      rd_word(2'd1, d); check("R4 addr", d, 32'h0);
      rd_word(2'd2, d); check("R4 gp0", d, 32'h0);
      rd_word(2'd3, d); check("R4 gp1", d, 32'h0);
      check("R4 outputs", {29'h0, irq_out, periph_rst, dma_en}, 32'h0);
   endtask

   task automatic t_words();
      logic [31:0] d;
      wr_word(2'd2, 32'h1234_5678);
      wr_word(2'd3, 32'hCAFE_F00D);
      rd_word(2'd2, d); check("R1 gp0", d, 32'h1234_5678);
      rd_word(2'd3, d); check("R1 gp1", d, 32'hCAFE_F00D);
      wr_word(2'd2, 32'hDEAD_BEEF, 4'h3);
      rd_word(2'd2, d); check("R2 partial write", d, 32'h1234_5678);
      rd_word(2'd3, d, 4'h7); check("R2 partial read", d, 32'h0);
   endtask

   task automatic t_ctrl_fields();
      logic [31:0] d;
      wr_word(2'd0, 32'h0E00_0005);
      rd_word(2'd0, d); check("R3 protected", d, 32'hA000_0000);
      wr_word(2'd0, 32'h0);
      rd_word(2'd0, d); check("R8 zero->drain", d, 32'hA000_0040);
      wr_word(2'd0, 32'h40);
      rd_word(2'd0, d); check("R8 drain self clear", d, 32'hA000_0000);
      wr_word(2'd0, 32'hC0);
      check("R7 pulse high", {31'h0, periph_rst}, 32'h1);
      @(negedge clk);
      check("R7 pulse one cycle", {31'h0, periph_rst}, 32'h0);
      rd_word(2'd0, d); check("R7 drain kept with reset", d, 32'hA000_00C0);
   endtask

   task automatic t_enable();
      logic [31:0] d;
      wr_word(2'd0, 32'h200);
      check("R9 en rises", {31'h0, dma_en}, 32'h1);
      rd_word(2'd0, d); check("R9 ctrl", d, 32'hA000_0200);
      wr_word(2'd0, 32'h100);
      check("R9 en falls", {31'h0, dma_en}, 32'h0);
   endtask

   task automatic t_irq();
      logic [31:0] d;
      @(negedge clk) periph_irq = 1'b1;
      @(negedge clk);
      check("R5 masked", {31'h0, irq_out}, 32'h0);
      rd_word(2'd0, d); check("R5 pending set", d & 32'h11, 32'h01);
      wr_word(2'd0, 32'h10);
      check("R6 enable raises", {31'h0, irq_out}, 32'h1);
      @(negedge clk) periph_irq = 1'b0;
      @(negedge clk);
      check("R5 fall drops", {31'h0, irq_out}, 32'h0);
      rd_word(2'd0, d); check("R5 pending clear", d, 32'hA000_0010);
      @(negedge clk) periph_irq = 1'b1;
      @(negedge clk);
      check("R5 rise raises", {31'h0, irq_out}, 32'h1);
      wr_word(2'd0, 32'h100);
      check("R6 disable drops", {31'h0, irq_out}, 32'h0);
      rd_word(2'd0, d); check("R6 pending kept", d, 32'hA000_0101);
      @(negedge clk) periph_irq = 1'b0;
      @(negedge clk);
   endtask

   task automatic t_same_cycle();
      logic [31:0] d;
      @(negedge clk);
      periph_irq = 1'b1;
      bus_sel = 1'b1; bus_wr = 1'b1; bus_be = 4'hF; bus_addr = 8'h00; bus_wdata = 32'h10;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
      check("R12 rise+write irq", {31'h0, irq_out}, 32'h1);
      rd_word(2'd0, d); check("R12 rise+write ctrl", d, 32'hA000_0011);
      @(negedge clk);
      periph_irq = 1'b0;
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 8'h00; bus_wdata = 32'h210;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
      check("R12 fall+write irq", {31'h0, irq_out}, 32'h0);
      rd_word(2'd0, d); check("R12 fall+write ctrl", d, 32'hA000_0210);
      wr_word(2'd0, 32'h100);
   endtask

   task automatic t_address();
      logic [31:0] d;
      wr_word(2'd1, 32'h0000_1000);
      rd_word(2'd0, d); check("R10 loaded set", d, 32'hA400_0100);
      wr_word(2'd0, 32'h10);
      rd_word(2'd0, d); check("R10 loaded sticky", d, 32'hA400_0010);
      @(negedge clk) begin xfer_valid = 1'b1; xfer_len = 16'd16; end
      @(negedge clk) xfer_len = 16'd3;
      @(negedge clk) xfer_valid = 1'b0;
      rd_word(2'd1, d); check("R11 increments", d, 32'h0000_1013);
      wr_word(2'd1, 32'hFFFF_FFFE);
      @(negedge clk) begin xfer_valid = 1'b1; xfer_len = 16'd4; end
      @(negedge clk) xfer_valid = 1'b0;
      rd_word(2'd1, d); check("R11 wraps", d, 32'h0000_0002);
      @(negedge clk);
      xfer_valid = 1'b1; xfer_len = 16'd8;
      bus_sel = 1'b1; bus_wr = 1'b1; bus_be = 4'hF; bus_addr = 8'h04; bus_wdata = 32'h500;
      @(negedge clk);
      xfer_valid = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0;
      rd_word(2'd1, d); check("R11 write wins", d, 32'h0000_0500);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_words();
      t_ctrl_fields();
      t_enable();
      t_irq();
      t_same_cycle();
      t_address();
      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++; n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule